// File: doc/BRIEF.md
# Serial Command Receiver with CRC-8 Frame Protection

This block is the serial slave front end of a register-based peripheral. The host shifts command frames in MSB first on the serial clock and commits each one with a rising edge on the latch input. Each committed frame carries an 8-bit address and a 16-bit data word. The block decodes three command addresses itself: a configuration word that turns frame protection on or off, a read request, and a software reset. Every other address leaves the block as a one-cycle write strobe with its address and data, for the register file behind it.

After reset, frames are 24 bits long. Once protection is turned on, frames grow to 32 bits and carry a trailing CRC byte over the payload. The generator polynomial is x^8 + x^2 + x + 1 and the register starts at zero. A frame is accepted only when the division of all 32 bits by that polynomial leaves no remainder. The check runs every 32 serial clocks whether or not the latch moves. A failing frame is dropped and sets a sticky fault flag, and the flag drives an active-low alarm. A read request makes the next frame shift out the requested register on the serial output. In protected mode a CRC byte computed by the block follows the register data.

The serial pins are brought into the system clock domain through a synchronizer and sampled there. The serial clock therefore has to stay well below the system clock.

Top module: `spi_crc_rx`

## Requirements
- R1: While reset is asserted and after it is released, crc_en_o=0, crc_flt_o=0, alarm_n_o=1, sdo_o=0, and no write or read strobe is issued.
- R2: With protection off, 24 bits shifted in MSB first and followed by a latch rise give exactly one wr_valid_o pulse, with wr_addr_o = frame bits 23:16 and wr_data_o = bits 15:0.
- R3: A committed frame to address 0x57 loads crc_en_o from data bit 0 and produces no write strobe. When crc_en_o is 1, frames are 32 bits long.
- R4: With protection on, a 32-bit frame gives one write of bits 31:24 (address) and bits 23:8 (data) when bits 7:0 equal the remainder of (payload * x^8) divided by 0x107.
- R5: A protected frame whose 32-bit division remainder is nonzero produces no write and sets crc_flt_o=1 and alarm_n_o=0. Every single-bit error is caught.
- R6: crc_flt_o stays at 1 across later good frames, and those frames still write.
- R7: A committed frame to address 0x96 is a software reset. It clears crc_flt_o, returns crc_en_o to 0 and produces no write strobe.
- R8: A committed configuration frame with data bit 0 = 0 clears crc_flt_o.
- R9: In protected mode a frame is evaluated at every 32nd serial clock without any latch. A bad frame sets the fault before any latch. When two frames arrive before a latch, only the last good one is written.
- R10: A latch rise with no serial clocks produces no write and resets the bit count, so a stray run of clock pulses is discarded and the next full frame is received correctly.
- R11: A committed frame to address 0x02 pulses rd_req_o with rd_addr_o = data bits 7:0. The next frame shifts out {rd_addr_o, rd_data_i} on sdo_o MSB first, one bit per serial clock. In protected mode these 24 bits are followed by their CRC byte.
- R12: A latch rise after fewer bits than a full frame produces no write.
- R13: Asserting rst_ni clears crc_flt_o and crc_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host, sampled on the rising sclk |
| latch_i | input | 1 | Frame commit strobe; the rising edge acts |
| sdo_o | output | 1 | Serial readback data |
| wr_valid_o | output | 1 | One-cycle strobe for a validated register write |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 16 | Write data |
| rd_req_o | output | 1 | One-cycle read request to the register file |
| rd_addr_o | output | 8 | Read address |
| rd_data_i | input | 16 | Read data, valid combinationally from rd_addr_o |
| crc_en_o | output | 1 | Frame protection enabled (32-bit frames) |
| crc_flt_o | output | 1 | Sticky CRC fault flag |
| alarm_n_o | output | 1 | Active-low alarm |

## Verification
The hardest case to reach is a fault that sticks through later traffic and is then cleared by one specific path. To get there, the bench needs a run of protected frames in which a single chosen bit is corrupted, followed by good frames, then a clearing command, then re-entry into protected mode. The bench sweeps the corrupted bit over all 32 positions. Each pass confirms that the write is blocked and that the fault survives a good write. Even positions clear through the configuration word and odd positions through the reset command. A second hard case is the free-running 32-clock evaluation. The bench reaches it by checking the fault before any latch, and by sending two frames back to back so that only the later one may be written.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned CRC_W   = 8;
  localparam int unsigned PAY_W   = ADDR_W + DATA_W;
  localparam int unsigned FRAME_W = PAY_W + CRC_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } payload_t;

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc_calc(logic [PAY_W-1:0] p);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = PAY_W - 1; i >= 0; i--) c = crc_step(c, p[i]);
    return c;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign lvl_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_crc_lfsr.sv
module spi_crc_lfsr
  import spi_crc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] next_o
);
  logic [CRC_W-1:0] state_q;

  assign next_o = crc_step(state_q, bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '0;
    else if (clr_i) state_q <= '0;
    else if (en_i)  state_q <= next_o;
  end
endmodule

// File: rtl/spi_rx_framer.sv
module spi_rx_framer
  import spi_crc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             crc_en_i,
  input  logic             sclk_rise_i,
  input  logic             latch_rise_i,
  input  logic             sdi_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             crc_err_o,
  output logic             commit_o,
  output payload_t         payload_o
);
  logic [CNT_W-1:0]   cnt_q, last_idx;
  logic [FRAME_W-2:0] sh_q;
  logic [FRAME_W-1:0] sh_nxt;
  logic               pend_q, last, good;
  payload_t           pay_q, pay_nxt;
  logic [CRC_W-1:0]   lfsr_nxt;

  spi_crc_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (latch_rise_i | last),
    .en_i   (sclk_rise_i),
    .bit_i  (sdi_i),
    .next_o (lfsr_nxt)
  );

  always_comb begin
    last_idx = crc_en_i ? CNT_W'(FRAME_W - 1) : CNT_W'(PAY_W - 1);
    last     = sclk_rise_i && !latch_rise_i && (cnt_q == last_idx);
    sh_nxt   = {sh_q, sdi_i};
    pay_nxt  = crc_en_i ? payload_t'(sh_nxt[FRAME_W-1:CRC_W])
                        : payload_t'(sh_nxt[PAY_W-1:0]);
    // unprotected frames are always good
    good     = !crc_en_i || (lfsr_nxt == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      pend_q <= 1'b0;
      pay_q  <= '0;
    end else if (latch_rise_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (sclk_rise_i) begin
      sh_q <= sh_nxt[FRAME_W-2:0];
      if (last) begin
        cnt_q  <= '0;
        pend_q <= good;
        if (good) pay_q <= pay_nxt;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign crc_err_o = last && !good;
  assign commit_o  = latch_rise_i && pend_q;
  assign payload_o = pay_q;
endmodule

// File: rtl/spi_crc_rx.sv
module spi_crc_rx
  import spi_crc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 8'h57,
  parameter logic [ADDR_W-1:0] RDREQ_ADDR  = 8'h02,
  parameter logic [ADDR_W-1:0] SWRST_ADDR  = 8'h96,
  parameter int unsigned       CRC_EN_BIT  = 0,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              latch_i,
  output logic              sdo_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              crc_en_o,
  output logic              crc_flt_o,
  output logic              alarm_n_o
);
  logic [2:0]       pin_lvl;
  logic [1:0]       prev_q;
  logic             sclk_rise, latch_rise;
  logic [CNT_W-1:0] rx_cnt;
  logic             crc_err, commit;
  payload_t         pay;
  logic             is_cfg, is_rd, is_rst, clr_flt;
  logic             wr_valid_q, rd_req_q, crc_en_q, crc_flt_q;
  logic [ADDR_W-1:0]  wr_addr_q, rd_addr_q;
  logic [DATA_W-1:0]  wr_data_q;
  logic [FRAME_W-1:0] tx_q;

  spi_pin_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({latch_i, sclk_i, sdi_i}),
    .lvl_o  (pin_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_lvl[2:1];
  end

  assign sclk_rise  = pin_lvl[1] & ~prev_q[0];
  assign latch_rise = pin_lvl[2] & ~prev_q[1];

  spi_rx_framer u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .crc_en_i     (crc_en_q),
    .sclk_rise_i  (sclk_rise),
    .latch_rise_i (latch_rise),
    .sdi_i        (pin_lvl[0]),
    .cnt_o        (rx_cnt),
    .crc_err_o    (crc_err),
    .commit_o     (commit),
    .payload_o    (pay)
  );

  always_comb begin
    is_cfg  = pay.addr == CFG_ADDR;
    is_rd   = pay.addr == RDREQ_ADDR;
    is_rst  = pay.addr == SWRST_ADDR;
    clr_flt = commit && (is_rst || (is_cfg && !pay.data[CRC_EN_BIT]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      rd_req_q   <= 1'b0;
      rd_addr_q  <= '0;
      crc_en_q   <= 1'b0;
      crc_flt_q  <= 1'b0;
    end else begin
      wr_valid_q <= commit && !is_cfg && !is_rd && !is_rst;
      rd_req_q   <= commit && is_rd;
      if (commit) begin
        wr_addr_q <= pay.addr;
        wr_data_q <= pay.data;
      end
      if (commit && is_rd) rd_addr_q <= pay.data[ADDR_W-1:0];
      if (commit && is_rst)      crc_en_q <= 1'b0;
      else if (commit && is_cfg) crc_en_q <= pay.data[CRC_EN_BIT];
      if (clr_flt)      crc_flt_q <= 1'b0;
      else if (crc_err) crc_flt_q <= 1'b1;
    end
  end

  // readback word loads one cycle after the request, when rd_data_i is valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tx_q <= '0;
    else if (rd_req_q)  tx_q <= {rd_addr_q, rd_data_i,
                                 crc_en_q ? crc_calc({rd_addr_q, rd_data_i}) : CRC_W'(0)};
    else if (sclk_rise) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
  end

  assign sdo_o      = tx_q[FRAME_W-1];
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign rd_req_o   = rd_req_q;
  assign rd_addr_o  = rd_addr_q;
  assign crc_en_o   = crc_en_q;
  assign crc_flt_o  = crc_flt_q;
  assign alarm_n_o  = ~crc_flt_q;
endmodule

module spi_crc_rx_chk
  import spi_crc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_o,
  input logic             crc_en_o,
  input logic             crc_flt_o,
  input logic             crc_err,
  input logic             commit,
  input logic             latch_rise,
  input logic             clr_flt,
  input logic [CNT_W-1:0] rx_cnt
);
  // R5
  err_sets_flt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err |=> crc_flt_o);
  // R6
  flt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(crc_flt_o) |-> $past(clr_flt));
  // R2
  wr_after_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(latch_rise));
  // R2
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
  // R3
  mode_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(crc_en_o) |-> $past(commit));
  // R9
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= (crc_en_o ? CNT_W'(FRAME_W - 1) : CNT_W'(PAY_W - 1)));
endmodule

bind spi_crc_rx spi_crc_rx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_o (wr_valid_o),
  .crc_en_o   (crc_en_o),
  .crc_flt_o  (crc_flt_o),
  .crc_err    (crc_err),
  .commit     (commit),
  .latch_rise (latch_rise),
  .clr_flt    (clr_flt),
  .rx_cnt     (rx_cnt)
);

// File: tb/spi_crc_rx_tb.sv
`timescale 1ns/1ps
module spi_crc_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, latch = 1'b0;
  logic sdo, wr_valid, rd_req, crc_en, crc_flt, alarm_n;
  logic [7:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;

  int total = 0, bad = 0, wr_cnt = 0, rd_cnt = 0;
  logic [7:0]  last_addr = '0, last_rd = '0;
  logic [15:0] last_data = '0;
  logic [31:0] rx_word = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rd_data = {rd_addr ^ 8'h5A, rd_addr};

  spi_crc_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .latch_i(latch),
    .sdo_o(sdo), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .crc_en_o(crc_en), .crc_flt_o(crc_flt), .alarm_n_o(alarm_n)
  );

  always @(negedge clk) begin
    if (wr_valid) begin wr_cnt++; last_addr = wr_addr; last_data = wr_data; end
    if (rd_req) begin rd_cnt++; last_rd = rd_addr; end
  end

  function automatic logic [7:0] crc_ref(logic [23:0] p);
    logic [31:0] v;
    v = {p, 8'h00};
    for (int i = 31; i >= 8; i--) if (v[i]) v = v ^ (32'h107 << (i - 8));
    return v[7:0];
  endfunction

  function automatic logic [31:0] f32(logic [7:0] a, logic [15:0] d);
    return {a, d, crc_ref({a, d})};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b);
    sdi = b;
    repeat (4) @(negedge clk);
    rx_word = {rx_word[30:0], sdo};
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) spi_bit(v[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_latch();
    latch = 1'b1;
    repeat (4) @(negedge clk);
    latch = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    send(v, n);
    pulse_latch();
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_up();
    end
  end

  initial begin
    int w;
    logic [7:0]  a;
    logic [15:0] d;
    logic [31:0] fr;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 flt in reset", crc_flt, 0);
    check("R1 alarm in reset", alarm_n, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 crc_en", crc_en, 0);
    check("R1 flt", crc_flt, 0);
    check("R1 alarm", alarm_n, 1);
    check("R1 sdo", sdo, 0);
    check("R1 no strobes", wr_cnt + rd_cnt, 0);

    // R2 24-bit writes, several patterns
    for (int k = 0; k < 8; k++) begin
      a = 8'h10 + 8'(k * 13);
      d = 16'(16'hA5C3 ^ (k * 16'h1111));
      w = wr_cnt;
      frame({8'h00, a, d}, 24);
      check("R2 one write", wr_cnt - w, 1);
      check("R2 addr", last_addr, a);
      check("R2 data", last_data, d);
    end

    // R12 partial frame
    w = wr_cnt;
    frame(32'h00123456, 13);
    check("R12 partial no write", wr_cnt - w, 0);
    // R10 NOP latch and glitch recovery
    pulse_latch();
    check("R10 nop no write", wr_cnt - w, 0);
    send(32'h1F, 5);
    pulse_latch();
    frame({8'h00, 8'h33, 16'hBEEF}, 24);
    check("R10 realigned write count", wr_cnt - w, 1);
    check("R10 realigned addr", last_addr, 8'h33);
    check("R10 realigned data", last_data, 16'hBEEF);

    // R11 24-bit readback
    w = rd_cnt;
    frame({8'h00, 8'h02, 16'h00AB}, 24);
    check("R11 rd_req", rd_cnt - w, 1);
    check("R11 rd_addr", last_rd, 8'hAB);
    rx_word = '0;
    frame({8'h00, 8'h40, 16'h0000}, 24);
    check("R11 sdo 24", rx_word[23:0], {8'hAB, 8'hAB ^ 8'h5A, 8'hAB});

    // R3 enable protection
    w = wr_cnt;
    frame({8'h00, 8'h57, 16'h0001}, 24);
    check("R3 crc_en", crc_en, 1);
    check("R3 no write", wr_cnt - w, 0);

    // R4 good protected frames
    for (int k = 0; k < 8; k++) begin
      a = 8'h20 + 8'(k * 7);
      d = 16'(16'h0F0F + k * 16'h0911);
      w = wr_cnt;
      frame(f32(a, d), 32);
      check("R4 one write", wr_cnt - w, 1);
      check("R4 addr", last_addr, a);
      check("R4 data", last_data, d);
    end
    check("R4 no fault", crc_flt, 0);

    // R11 protected readback
    frame(f32(8'h02, 16'h0031), 32);
    check("R11 rd_addr crc", last_rd, 8'h31);
    rx_word = '0;
    frame(f32(8'h41, 16'h0000), 32);
    check("R11 sdo 32", rx_word,
          {8'h31, 8'h31 ^ 8'h5A, 8'h31, crc_ref({8'h31, 8'h31 ^ 8'h5A, 8'h31})});

    // R5/R6/R7/R8 single-bit error sweep over all positions
    for (int b = 0; b < 32; b++) begin
      fr = f32(8'h60, 16'(16'h1234 + b));
      w = wr_cnt;
      frame(fr ^ (32'h1 << b), 32);
      check("R5 bad blocked", wr_cnt - w, 0);
      check("R5 flt set", crc_flt, 1);
      check("R5 alarm low", alarm_n, 0);
      frame(f32(8'h61, 16'(b)), 32);
      check("R6 good still writes", wr_cnt - w, 1);
      check("R6 flt sticky", crc_flt, 1);
      if (b % 2 == 0) begin
        frame(f32(8'h57, 16'h0000), 32);
        check("R8 cfg clears flt", crc_flt, 0);
        check("R8 alarm high", alarm_n, 1);
      end else begin
        frame(f32(8'h96, 16'h0000), 32);
        check("R7 swrst clears flt", crc_flt, 0);
        check("R7 swrst crc_en", crc_en, 0);
      end
      check("R7 R8 no write", wr_cnt - w, 1);
      frame({8'h00, 8'h57, 16'h0001}, 24);
    end

    // R9 evaluation without latch
    send(f32(8'h70, 16'h5555) ^ 32'h0000_0100, 32);
    repeat (4) @(negedge clk);
    check("R9 flt before latch", crc_flt, 1);
    pulse_latch();
    frame(f32(8'h57, 16'h0000), 32);
    frame({8'h00, 8'h57, 16'h0001}, 24);
    w = wr_cnt;
    send(f32(8'h71, 16'h1111), 32);
    send(f32(8'h72, 16'h2222), 32);
    pulse_latch();
    check("R9 one write of two", wr_cnt - w, 1);
    check("R9 last frame addr", last_addr, 8'h72);
    check("R9 last frame data", last_data, 16'h2222);

    // R13 hardware reset clears fault
    frame(f32(8'h73, 16'h0000) ^ 32'h1, 32);
    check("R13 flt before reset", crc_flt, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R13 flt cleared", crc_flt, 0);
    check("R13 crc_en cleared", crc_en, 0);

    done = 1;
    finish_up();
  end
endmodule